// File: doc/BRIEF.md
# Accumulator Negate Unit with Condition Codes

This block forms the two's-complement negation of a 56-bit guard-bit accumulator and rebuilds the condition-code byte that goes with it. The accumulator has an 8-bit extension field on top, a 24-bit high word in the middle and a 24-bit low word at the bottom. The result replaces the accumulator contents in the surrounding datapath. The extension-in-use and unnormalized flags depend on a 2-bit scaling-mode selector that travels with each operand. The limit flag is sticky. The sign-magnitude and carry bits of the incoming condition byte pass through untouched.

Operands enter on a valid/ready stream: one operand, condition byte and scaling mode per beat. Results leave on a second valid/ready stream through a single register stage. A beat is accepted when `in_valid` and `in_ready` are both high at a rising clock edge. The register can take a new beat whenever it is empty or its current result is leaving in the same cycle. When the consumer holds `out_ready` low, the result stays on the outputs unchanged, and back-pressure reaches the producer through `in_ready` in the same cycle.

Top module: `acc_negate_unit`

## Requirements
- R1: For an accepted operand `a`, `out_acc` equals `(0 - a) mod 2^56`. For example, operand 0x00_123456_789ABC gives 0xFF_EDCBA9_876544.
- R2: Condition bit 3 (negative) equals bit 55 of `out_acc`.
- R3: Condition bit 2 (zero) is 1 exactly when all 56 bits of `out_acc` are 0.
- R4: Condition bit 1 (overflow) is 1 only for operand 0x80_000000_000000. For that operand the result equals the operand.
- R5: Condition bit 6 (limit) equals the incoming bit 6 ORed with the overflow bit. Bit 6 is never cleared.
- R6: Condition bit 5 (extension in use) is 0 when a group of result bits is all ones or all zeros, and 1 otherwise. The group is bits 55..47 for scaling mode 00 (none), bits 55..48 for mode 01 (scale down) and bits 55..46 for mode 10 (scale up). Mode 11 behaves as mode 00.
- R7: Condition bit 4 (unnormalized) is 1 when two adjacent result bits are equal. The pair is bits 47/46 for mode 00 and 11, bits 48/47 for mode 01, and bits 46/45 for mode 10.
- R8: Condition bits 7 and 0 of the output equal bits 7 and 0 of the accepted condition byte.
- R9: A beat is accepted when `in_valid` and `in_ready` are both 1 at a rising edge. `in_ready` equals `!out_valid || out_ready`. The result is presented with `out_valid` = 1 in the next cycle, and results leave in acceptance order.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_acc` and `out_ccr` keep their values across the edge.
- R11: During and directly after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand beat present |
| in_ready | output | 1 | Unit can accept an operand this cycle |
| in_acc | input | 56 | Accumulator operand (extension:high:low) |
| in_ccr | input | 8 | Current condition-code byte |
| in_scale | input | 2 | Scaling mode: 00 none, 01 down, 10 up, 11 as none |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_acc | output | 56 | Negated accumulator |
| out_ccr | output | 8 | Updated condition-code byte |

## Verification
Random operands almost never produce the single overflowing input. They also rarely place the sign-extension boundary exactly where each scaling mode looks for it. The stimulus therefore sends directed operands: zero, all ones, the largest positive value, the overflowing value, and values whose sign edge falls at bits 45 through 48. Each of these goes through every scaling mode, with the incoming limit bit both clear and set. A stall case, in which a full output register meets a second waiting beat, is forced by holding `out_ready` low for several cycles. Random back-pressure then covers the other handshake phases.

// File: rtl/acc_neg_pkg.sv
package acc_neg_pkg;

  typedef enum logic [1:0] {
    SCALE_NONE = 2'b00,
    SCALE_DOWN = 2'b01,
    SCALE_UP   = 2'b10,
    SCALE_RSVD = 2'b11
  } scale_mode_e;

  localparam int CC_W   = 8;
  localparam int CC_S   = 7;
  localparam int CC_L   = 6;
  localparam int CC_E   = 5;
  localparam int CC_U   = 4;
  localparam int CC_N   = 3;
  localparam int CC_Z   = 2;
  localparam int CC_V   = 1;
  localparam int CC_C   = 0;

endpackage

// File: rtl/acc_neg_arith.sv
// Segmented two's-complement negation: invert and add one, the +1 carry
// rippling low word -> high word -> extension. The carry out of the top
// segment is 1 only when the operand (and so the result) is zero.
module acc_neg_arith #(
  parameter int EXT_W = 8,
  parameter int HI_W  = 24,
  parameter int LO_W  = 24,
  localparam int ACC_W = EXT_W + HI_W + LO_W
) (
  input  logic [ACC_W-1:0] acc_i,
  output logic [ACC_W-1:0] neg_o,
  output logic             zero_o,
  output logic             negative_o,
  output logic             ovf_o
);

  localparam int NSEG = 3;
  localparam int SEG_W [NSEG] = '{LO_W, HI_W, EXT_W};
  localparam int SEG_O [NSEG] = '{0, LO_W, LO_W + HI_W};

  logic [NSEG:0] carry;
  assign carry[0] = 1'b1;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    logic [SEG_W[g]:0] sum;
    assign sum = {1'b0, ~acc_i[SEG_O[g] +: SEG_W[g]]}
               + {{SEG_W[g]{1'b0}}, carry[g]};
    assign neg_o[SEG_O[g] +: SEG_W[g]] = sum[SEG_W[g]-1:0];
    assign carry[g+1] = sum[SEG_W[g]];
  end

  assign zero_o     = carry[NSEG];
  assign negative_o = neg_o[ACC_W-1];
  // Only the most negative value keeps its sign bit after negation.
  assign ovf_o      = acc_i[ACC_W-1] & neg_o[ACC_W-1];

endmodule

// File: rtl/acc_neg_flags.sv
// Scaling-dependent extension-in-use and unnormalized flags.
module acc_neg_flags #(
  parameter int EXT_W = 8,
  parameter int ACC_W = 56,
  localparam int FS = ACC_W - EXT_W - 1
) (
  input  logic [ACC_W-1:0]            res_i,
  input  acc_neg_pkg::scale_mode_e    scale_i,
  output logic                        ext_use_o,
  output logic                        unnorm_o
);
  import acc_neg_pkg::*;

  logic [ACC_W-1:FS-1] grp_up;
  logic [ACC_W-1:FS]   grp_none;
  logic [ACC_W-1:FS+1] grp_down;
  logic e_none, e_down, e_up;
  logic u_none, u_down, u_up;

  assign grp_up   = res_i[ACC_W-1:FS-1];
  assign grp_none = res_i[ACC_W-1:FS];
  assign grp_down = res_i[ACC_W-1:FS+1];

  assign e_none = ~((&grp_none) | ~(|grp_none));
  assign e_down = ~((&grp_down) | ~(|grp_down));
  assign e_up   = ~((&grp_up)   | ~(|grp_up));

  assign u_none = ~(res_i[FS]   ^ res_i[FS-1]);
  assign u_down = ~(res_i[FS+1] ^ res_i[FS]);
  assign u_up   = ~(res_i[FS-1] ^ res_i[FS-2]);

  always_comb begin
    unique case (scale_i)
      SCALE_DOWN: begin ext_use_o = e_down; unnorm_o = u_down; end
      SCALE_UP:   begin ext_use_o = e_up;   unnorm_o = u_up;   end
      default:    begin ext_use_o = e_none; unnorm_o = u_none; end
    endcase
  end

endmodule

// File: rtl/acc_neg_stage.sv
// Single valid/ready register slice.
module acc_neg_stage #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);

  logic load;
  assign in_ready = ~out_valid | out_ready;
  assign load     = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (load)     out_data  <= in_data;
    end
  end

endmodule

// File: rtl/acc_negate_unit.sv
module acc_negate_unit #(
  parameter int EXT_W = 8,
  parameter int HI_W  = 24,
  parameter int LO_W  = 24,
  localparam int ACC_W = EXT_W + HI_W + LO_W,
  localparam int CCW   = acc_neg_pkg::CC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [ACC_W-1:0] in_acc,
  input  logic [CCW-1:0]   in_ccr,
  input  logic [1:0]       in_scale,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [ACC_W-1:0] out_acc,
  output logic [CCW-1:0]   out_ccr
);
  import acc_neg_pkg::*;

  localparam int DW = ACC_W + CCW;

  logic [ACC_W-1:0] neg;
  logic             is_zero, is_neg, is_ovf;
  logic             ext_use, unnorm;
  logic [CCW-1:0]   ccr_next;
  logic [DW-1:0]    stage_out;

  acc_neg_arith #(.EXT_W(EXT_W), .HI_W(HI_W), .LO_W(LO_W)) u_arith (
    .acc_i      (in_acc),
    .neg_o      (neg),
    .zero_o     (is_zero),
    .negative_o (is_neg),
    .ovf_o      (is_ovf)
  );

  acc_neg_flags #(.EXT_W(EXT_W), .ACC_W(ACC_W)) u_flags (
    .res_i     (neg),
    .scale_i   (scale_mode_e'(in_scale)),
    .ext_use_o (ext_use),
    .unnorm_o  (unnorm)
  );

  always_comb begin
    ccr_next       = in_ccr;
    ccr_next[CC_L] = in_ccr[CC_L] | is_ovf;
    ccr_next[CC_E] = ext_use;
    ccr_next[CC_U] = unnorm;
    ccr_next[CC_N] = is_neg;
    ccr_next[CC_Z] = is_zero;
    ccr_next[CC_V] = is_ovf;
  end

  acc_neg_stage #(.DW(DW)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   ({neg, ccr_next}),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (stage_out)
  );

  assign out_acc = stage_out[DW-1:CCW];
  assign out_ccr = stage_out[CCW-1:0];

endmodule

// File: rtl/acc_negate_unit_chk.sv
module acc_negate_unit_chk #(
  parameter int ACC_W = 56
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [ACC_W-1:0] in_acc,
  input logic [7:0]       in_ccr,
  input logic             out_valid,
  input logic             out_ready,
  input logic [ACC_W-1:0] out_acc,
  input logic [7:0]       out_ccr
);

  logic fire;
  assign fire = in_valid & in_ready;

  // R1
  neg_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (ACC_W'(out_acc + $past(in_acc)) == '0));

  // R2
  neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_ccr[3] == out_acc[ACC_W-1]));

  // R3
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_ccr[2] == (out_acc == '0)));

  // R4
  ovf_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ccr[1]) |-> (out_acc == {1'b1, {(ACC_W-1){1'b0}}}));

  // R5
  limit_on_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ccr[1]) |-> out_ccr[6]);

  // R5
  limit_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_ccr[6]) |=> out_ccr[6]);

  // R8
  pass_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (out_ccr[7] == $past(in_ccr[7]) && out_ccr[0] == $past(in_ccr[0])));

  // R9
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_acc) && $stable(out_ccr)));

endmodule

bind acc_negate_unit acc_negate_unit_chk #(.ACC_W(ACC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_acc    (in_acc),
  .in_ccr    (in_ccr),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_acc   (out_acc),
  .out_ccr   (out_ccr)
);

// File: tb/acc_negate_unit_tb.sv
`timescale 1ns/1ps
module acc_negate_unit_tb;

  typedef struct packed {
    logic [55:0] acc;
    logic [7:0]  ccr;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [55:0] in_acc = '0;
  logic [7:0]  in_ccr = '0;
  logic [1:0]  in_scale = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [55:0] out_acc;
  logic [7:0]  out_ccr;

  int   errors = 0;
  int   checks = 0;
  bit   ready_rand = 1'b0;
  bit   hold_low = 1'b0;
  bit   done = 1'b0;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  acc_negate_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_acc(in_acc), .in_ccr(in_ccr), .in_scale(in_scale),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_acc(out_acc), .out_ccr(out_ccr)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [55:0] a, input logic [7:0] c,
                                 input logic [1:0] m);
    exp_t   e;
    logic [55:0] r;
    logic   v, eb, ub;
    r  = 56'(0 - a);
    v  = (a == 56'h80_000000_000000);
    case (m)
      2'b01: begin
        eb = !(r[55:48] == 8'h00 || r[55:48] == 8'hFF);
        ub = (r[48] == r[47]);
      end
      2'b10: begin
        eb = !(r[55:46] == 10'h000 || r[55:46] == 10'h3FF);
        ub = (r[46] == r[45]);
      end
      default: begin
        eb = !(r[55:47] == 9'h000 || r[55:47] == 9'h1FF);
        ub = (r[47] == r[46]);
      end
    endcase
    e.acc = r;
    e.ccr = {c[7], c[6] | v, eb, ub, r[55], (r == 56'd0), v, c[0]};
    return e;
  endfunction

  // Driver: entered and left at a falling edge.
  task automatic send(input logic [55:0] a, input logic [7:0] c, input logic [1:0] m);
    bit fire;
    in_valid = 1'b1; in_acc = a; in_ccr = c; in_scale = m;
    forever begin
      #1;
      fire = in_ready;
      // R9: ready follows output occupancy and consumer readiness
      check(in_ready == (!out_valid || out_ready), "R9 in_ready", 64'(in_ready),
            64'(!out_valid || out_ready));
      if (fire) sb.push_back(model(a, c, m));
      @(negedge clk);
      if (fire) break;
    end
  endtask

  // Monitor / scoreboard
  initial begin
    bit          prev_stall = 1'b0;
    logic [55:0] prev_acc = '0;
    logic [7:0]  prev_ccr = '0;
    exp_t        e;
    forever begin
      @(negedge clk);
      out_ready = hold_low ? 1'b0 : (ready_rand ? 1'($urandom % 2) : 1'b1);
      #1;
      if (rst_n) begin
        if (prev_stall) begin
          // R10: stalled result held
          check(out_valid && out_acc == prev_acc && out_ccr == prev_ccr, "R10 hold",
                {out_acc, out_ccr}, {prev_acc, prev_ccr});
        end
        if (out_valid && out_ready) begin
          if (sb.size() == 0) begin
            check(1'b0, "R9 unexpected result", 64'(out_acc), 64'd0);
          end else begin
            e = sb.pop_front();
            check(out_acc == e.acc, "R1 result", 64'(out_acc), 64'(e.acc));
            check(out_ccr[3] == e.ccr[3], "R2 N", 64'(out_ccr[3]), 64'(e.ccr[3]));
            check(out_ccr[2] == e.ccr[2], "R3 Z", 64'(out_ccr[2]), 64'(e.ccr[2]));
            check(out_ccr[1] == e.ccr[1], "R4 V", 64'(out_ccr[1]), 64'(e.ccr[1]));
            check(out_ccr[6] == e.ccr[6], "R5 L", 64'(out_ccr[6]), 64'(e.ccr[6]));
            check(out_ccr[5] == e.ccr[5], "R6 E", 64'(out_ccr[5]), 64'(e.ccr[5]));
            check(out_ccr[4] == e.ccr[4], "R7 U", 64'(out_ccr[4]), 64'(e.ccr[4]));
            check({out_ccr[7], out_ccr[0]} == {e.ccr[7], e.ccr[0]}, "R8 S/C",
                  64'({out_ccr[7], out_ccr[0]}), 64'({e.ccr[7], e.ccr[0]}));
          end
        end
        prev_stall = out_valid && !out_ready;
        prev_acc   = out_acc;
        prev_ccr   = out_ccr;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", 64'd0, 64'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [55:0] corners [10];
    corners[0] = 56'h00_000000_000000;
    corners[1] = 56'h80_000000_000000;
    corners[2] = 56'hFF_FFFFFF_FFFFFF;
    corners[3] = 56'h00_123456_789ABC;
    corners[4] = 56'h7F_FFFFFF_FFFFFF;
    corners[5] = 56'h00_000000_000001;
    corners[6] = 56'h00_200000_000000;
    corners[7] = 56'h00_400000_000000;
    corners[8] = 56'h00_800000_000000;
    corners[9] = 56'h01_000000_000000;

    repeat (3) @(negedge clk);
    #1;
    // R11: reset state
    check(out_valid == 1'b0, "R11 out_valid in reset", 64'(out_valid), 64'd0);
    check(in_ready == 1'b1, "R11 in_ready in reset", 64'(in_ready), 64'd1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R11 out_valid after reset", 64'(out_valid), 64'd0);
    @(negedge clk);

    // R1 worked example, then corners across all modes and limit states
    send(56'h00_123456_789ABC, 8'h00, 2'b00);
    for (int i = 0; i < 10; i++) begin
      for (int m = 0; m < 4; m++) begin
        send(corners[i], 8'h00, 2'(m));
        send(corners[i], 8'hC1, 2'(m));   // R5 sticky L, R8 S and C set
      end
    end

    // R10: forced stall with a second beat waiting
    hold_low = 1'b1;
    fork
      begin
        send(56'h80_000000_000000, 8'h00, 2'b00);
        send(56'h12_345678_9ABCDE, 8'h81, 2'b10);
      end
      begin
        repeat (6) @(negedge clk);
        hold_low = 1'b0;
      end
    join

    // Random operands under random back-pressure
    ready_rand = 1'b1;
    for (int i = 0; i < 300; i++) begin
      send({24'($urandom), 32'($urandom)}, 8'($urandom), 2'($urandom));
    end
    in_valid = 1'b0;
    ready_rand = 1'b0;
    repeat (10) @(negedge clk);
    check(sb.size() == 0, "R9 all results delivered", 64'(sb.size()), 64'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule